// File: doc/BRIEF.md
# Move-Triggered Arithmetic Function Unit

This block is one function unit of a processor whose only instruction is a data move. It has a staging port, a trigger port and one result port. A move into the staging port only parks a value in the unit. A move into the trigger port supplies the second value and captures the operation code. That move also starts the computation, so computing is a side effect of the transport.

The result port is a plain register. It shows a new value once the latency of the chosen operation has passed. Single-cycle operations are add, subtract, and, or and xor. The multiply takes three cycles and runs as a pipeline. There are no interlocks and no stall. The compiler must schedule its reads of the result port so that they are neither too early nor too late. A read that is too early sees the previous result. A read that is too late sees whatever result has replaced it.

Top module: `tta_fu`

## Requirements
- R1: A staging write (`stage_we`=1 with `trig_we`=0) only stores `stage_data`. It changes nothing on `result`, and the value of `trig_opc` on that cycle has no effect.
- R2: A trigger write computes with A = the staged value and B = `trig_data`. When `stage_we` and `trig_we` are high in the same cycle, A is the value being staged in that cycle.
- R3: `trig_opc` is sampled only with `trig_we`. The codes are: 0 = A+B, 1 = A-B, 2 = A&B, 3 = A|B, 4 = A^B, 5 = A*B keeping the low DATA_W bits.
- R4: Codes 0 to 4 place their result on `result` after the clock edge that samples the trigger. It is visible in the cycle right after the trigger cycle.
- R5: Code 5 places its result on `result` after the third clock edge counted from and including the trigger edge. The two cycles before that still show the previous result.
- R6: The multiply accepts a trigger every cycle. Back-to-back multiplies appear on `result` on consecutive cycles, in trigger order.
- R7: When a single-cycle result and an older multiply result are due on the same edge, the single-cycle result is written and the multiply result is discarded.
- R8: Codes 6 and 7 start nothing and leave `result` unchanged.
- R9: `result` keeps its value until a later operation's result replaces it.
- R10: An active-low `rst_n` clears the staged operand, `result` and every in-flight multiply stage to zero. A multiply in flight at reset never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stage_we | input | 1 | Move into the staging operand port |
| stage_data | input | DATA_W | Value moved into the staging port |
| trig_we | input | 1 | Move into the trigger port; starts an operation |
| trig_data | input | DATA_W | Value moved into the trigger port (operand B) |
| trig_opc | input | 3 | Operation code sampled with the trigger |
| result | output | DATA_W | Result port |

## Verification
The bench runs the unit at an 8-bit width. Every operation code meets every pair drawn from a set of corner operands: zero, one, two, the sign boundary, alternating patterns and all ones. This set separates carry, borrow and product truncation from plain bitwise behaviour. Multiply reads taken one and two cycles early show whether the latency is exact rather than merely bounded. Same-cycle staging and triggering shows whether the staged value is forwarded. Back-to-back multiplies, a multiply overtaken by an add, and a reset while a product is in flight show ordering, the younger-wins rule and pipeline flushing. None of these can be seen from single isolated operations.

// File: rtl/tta_fu_pkg.sv
package tta_fu_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_AND  = 3'd2,
    OPC_OR   = 3'd3,
    OPC_XOR  = 3'd4,
    OPC_MUL  = 3'd5,
    OPC_RSV6 = 3'd6,
    OPC_RSV7 = 3'd7
  } opc_e;

  function automatic logic opc_is_single(input opc_e opc);
    return (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_AND) ||
           (opc == OPC_OR)  || (opc == OPC_XOR);
  endfunction

endpackage

// File: rtl/tta_fu_operand_reg.sv
module tta_fu_operand_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] eff
);

  logic [DATA_W-1:0] q_r;

  // the value a same-cycle trigger sees: the one being staged now, else the stored one
  always_comb begin
    eff = we ? din : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (we) begin
      q_r <= din;
    end
  end

  assign q = q_r;

  // R2
  opnd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(din)));

endmodule

// File: rtl/tta_fu_alu.sv
module tta_fu_alu
  import tta_fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  opc_e              opc,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (opc)
      OPC_ADD: y = a + b;
      OPC_SUB: y = a - b;
      OPC_AND: y = a & b;
      OPC_OR:  y = a | b;
      OPC_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/tta_fu_mul_pipe.sv
module tta_fu_mul_pipe #(
  parameter int DATA_W  = 32,
  parameter int MUL_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              done,
  output logic [DATA_W-1:0] prod
);

  // the result register in the parent adds the last stage of latency
  localparam int NSTG = MUL_LAT - 1;

  logic [NSTG-1:0]   vld_q, vld_d;
  logic [DATA_W-1:0] dat_q [NSTG];
  logic [DATA_W-1:0] dat_d [NSTG];

  always_comb begin
    vld_d[0] = start;
    dat_d[0] = a * b;
    for (int i = 1; i < NSTG; i++) begin
      vld_d[i] = vld_q[i-1];
      dat_d[i] = dat_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSTG; i++) dat_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < NSTG; i++) begin
        if (vld_d[i]) dat_q[i] <= dat_d[i];
      end
    end
  end

  assign done = vld_q[NSTG-1];
  assign prod = dat_q[NSTG-1];

  // R6
  mul_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> vld_q[0]);

  for (genvar g = 1; g < NSTG; g++) begin : g_stage_chk
    // R6
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g-1] |=> (vld_q[g] && (dat_q[g] == $past(dat_q[g-1]))));
  end

endmodule

// File: rtl/tta_fu.sv
module tta_fu
  import tta_fu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MUL_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic [DATA_W-1:0] stage_data,
  input  logic              trig_we,
  input  logic [DATA_W-1:0] trig_data,
  input  logic [OPC_W-1:0]  trig_opc,
  output logic [DATA_W-1:0] result
);

  opc_e              opc;
  logic [DATA_W-1:0] opnd_q, opnd_eff, alu_y, mul_prod;
  logic              single_go, mul_go, mul_done;
  logic              res_en;
  logic [DATA_W-1:0] res_d, res_q;

  assign opc = opc_e'(trig_opc);

  tta_fu_operand_reg #(.DATA_W(DATA_W)) u_opnd (
    .clk(clk), .rst_n(rst_n), .we(stage_we), .din(stage_data),
    .q(opnd_q), .eff(opnd_eff)
  );

  tta_fu_alu #(.DATA_W(DATA_W)) u_alu (
    .a(opnd_eff), .b(trig_data), .opc(opc), .y(alu_y)
  );

  assign single_go = trig_we && opc_is_single(opc);
  assign mul_go    = trig_we && (opc == OPC_MUL);

  tta_fu_mul_pipe #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_go), .a(opnd_eff), .b(trig_data),
    .done(mul_done), .prod(mul_prod)
  );

  // younger single-cycle result wins over a multiply due on the same edge
  always_comb begin
    res_en = single_go || mul_done;
    res_d  = single_go ? alu_y : mul_prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign result = res_q;

  // R4
  add_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && opc == OPC_ADD) |=> (result == $past(opnd_eff + trig_data)));

  // R7
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_go && mul_done) |=> (result == $past(alu_y)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_we && !mul_done) |=> $stable(result));

  // R8
  rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && (opc == OPC_RSV6 || opc == OPC_RSV7) && !mul_done) |=> $stable(result));

  if (MUL_LAT == 3) begin : g_mul3_chk
    // R5
    mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_go ##1 !single_go ##1 !single_go) |=> (result == $past(opnd_eff * trig_data, 3)));
  end

endmodule

// File: tb/sim_tta_fu.sv
`timescale 1ns/1ps
module sim_tta_fu;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         stage_we, trig_we;
  logic [W-1:0] stage_data, trig_data;
  logic [2:0]   trig_opc;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_res;

  always #4 clk = ~clk;

  tta_fu #(.DATA_W(W), .MUL_LAT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_data(stage_data),
    .trig_we(trig_we), .trig_data(trig_data), .trig_opc(trig_opc), .result(result)
  );

  function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return p[W-1:0];
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] corner(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h7f;
      4: return 8'h80; 5: return 8'haa; 6: return 8'h55; default: return 8'hff;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: result=%h expected=%h at %0t", req, result, exp, $time);
    end
  endtask

  task automatic idle();
    stage_we = 1'b0; trig_we = 1'b0; stage_data = '0; trig_data = '0; trig_opc = 3'd0;
  endtask

  task automatic stage(input logic [W-1:0] a);
    @(negedge clk);
    idle(); stage_we = 1'b1; stage_data = a; trig_opc = 3'd5;  // opcode ignored: R1
    @(negedge clk);
    idle();
    chk("R1", exp_res);
  endtask

  // full operation: trigger then check timing according to the opcode
  task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] nv;
    nv = model(op, a, b);
    @(negedge clk);
    idle(); trig_we = 1'b1; trig_data = b; trig_opc = op;
    @(negedge clk);
    idle();
    if (op <= 3'd4) begin
      chk("R3/R4", nv); exp_res = nv;
    end else if (op == 3'd5) begin
      chk("R5 early1", exp_res);
      @(negedge clk); chk("R5 early2", exp_res);
      @(negedge clk); chk("R3/R5", nv); exp_res = nv;
    end else begin
      chk("R8", exp_res);
      @(negedge clk); chk("R8", exp_res);
      @(negedge clk); chk("R8", exp_res);
    end
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: result=%h expected=finish", result);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    exp_res = '0;
    #20;
    chk("R10 reset", 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // sweep all opcodes over corner operand pairs
    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        stage(corner(ia));
        for (int ib = 0; ib < 8; ib++) begin
          run_op(3'(op), corner(ia), corner(ib));
        end
      end
    end

    // R2: same-cycle staging is forwarded to the trigger
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] a, b;
      a = corner(k + 1); b = corner(7 - k);
      @(negedge clk);
      idle(); stage_we = 1'b1; stage_data = a; trig_we = 1'b1; trig_data = b;
      trig_opc = 3'(k % 5);
      @(negedge clk);
      idle();
      exp_res = model(3'(k % 5), a, b);
      chk("R2 forward", exp_res);
    end

    // R6: back-to-back multiplies retire in order
    stage(8'h13);
    @(negedge clk); idle(); trig_we = 1'b1; trig_opc = 3'd5; trig_data = 8'h03;
    @(negedge clk); trig_data = 8'h05;
    @(negedge clk); trig_data = 8'h11;
    @(negedge clk); idle(); chk("R6 first", model(3'd5, 8'h13, 8'h03));
    @(negedge clk); chk("R6 second", model(3'd5, 8'h13, 8'h05));
    @(negedge clk); chk("R6 third", model(3'd5, 8'h13, 8'h11));
    exp_res = model(3'd5, 8'h13, 8'h11);

    // R9: result holds while nothing is issued
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk("R9 hold", exp_res);
    end

    // R7: add issued two cycles after a multiply lands on the same edge and wins
    stage(8'h21);
    @(negedge clk); idle(); trig_we = 1'b1; trig_opc = 3'd5; trig_data = 8'h07;
    @(negedge clk); idle(); chk("R7 before", exp_res);
    @(negedge clk); trig_we = 1'b1; trig_opc = 3'd0; trig_data = 8'h40;
    chk("R7 before", exp_res);
    @(negedge clk); idle(); chk("R7 younger wins", 8'h61);
    @(negedge clk); chk("R7 mul dropped", 8'h61);
    @(negedge clk); chk("R7 mul dropped", 8'h61);
    exp_res = 8'h61;

    // R10: reset while a multiply is in flight flushes it and clears the stage
    stage(8'h0f);
    @(negedge clk); idle(); trig_we = 1'b1; trig_opc = 3'd5; trig_data = 8'h0f;
    @(negedge clk); idle();
    #1 rst_n = 1'b0;
    #1 chk("R10 async clear", 8'h00);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    exp_res = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R10 flushed", 8'h00);
    end
    run_op(3'd0, 8'h00, 8'h05);  // staged operand must read as zero: R10

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule